// File: doc/BRIEF.md
# Cascadable Successive Approximation Register

This block is the digital half of a successive approximation analog-to-digital converter. It holds the trial code that drives an external DAC, and it steps through the bits from the most significant down. Each clock it takes the comparator's verdict on the current trial bit, stores that verdict, and sets the next lower bit low as the new trial. A start pulse loads the first trial code. An active-low completion flag falls once the last bit has been decided. With the comparator replaced by a serial data stream, the same block works as an MSB-first serial-to-parallel converter.

Several stages chain into a longer word. Each stage's completion flag drives the active-low enable of the next, less significant stage. A stage waiting on its enable shows its top bit forced high and ignores serial data. It starts deciding bits on the clock after the stage above completes. All stages share the clock, the start and the serial bit.

Serial data does not use a valid/ready handshake. The comparator output is sampled on every enabled clock, so the block never stalls its source. The only form of back-pressure is the enable, which holds a stage idle.

Top module: `sar_register`

## Requirements
- R1: A rising clock edge with `start_n` low loads the register with the top bit 0 and every other bit 1, and drives `done_n` high. With `enable_n` low, `q` then reads 0x7F.
- R2: On each rising edge with `start_n` high, `enable_n` low and a conversion in progress, `ser_bit` is stored into the bit under trial, and the next lower bit is cleared to 0 as the new trial. Bits already decided keep their values, and untried bits stay 1.
- R3: After exactly 8 enabled clocks following a start, `done_n` is low and `q` holds the ideal comparator's target code. Until then `done_n` stays high.
- R4: Once `done_n` is low, further clocks without a start leave `q` unchanged and `done_n` low, whatever `ser_bit` is.
- R5: While `enable_n` is high and no bit has yet been decided since the start, `q[7]` reads 1, the register does not advance, and `q` reads 0xFF. When `enable_n` falls, `q` reads 0x7F again.
- R6: The first enabled clock after a wait stores `ser_bit` into bit 7: with `ser_bit` 0, `q` becomes 0x3F; with `ser_bit` 1, it becomes 0xBF.
- R7: Start overrides enable and any conversion in progress. A start edge abandons the sequence and reloads the R1 pattern, even with `enable_n` high.
- R8: `q7_bar` is always the complement of the `q[7]` output, including the forced value.
- R9: With two stages chained, the upper stage's `done_n` drives the lower stage's `enable_n`. Sixteen clocks after a start, the pair then holds the 16-bit target code and the lower stage's `done_n` is low.
- R10: While `rst_n` is low, `q` reads 0xFF and `done_n` is low, that is, idle and complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset to the idle, complete state |
| start_n | input | 1 | Active-low start; loads the first trial code |
| enable_n | input | 1 | Active-low enable; high holds the stage waiting |
| ser_bit | input | 1 | Comparator verdict or serial data bit |
| q | output | 8 | Parallel trial/result code, bit 7 most significant |
| q7_bar | output | 1 | Complement of `q[7]` |
| done_n | output | 1 | Active-low conversion complete; drives the next stage's enable |

## Verification
The bench sweeps all 256 codes through one stage with an ideal comparator, and checks the intermediate code after every clock. A design that cleared the wrong trial bit, or that raised completion one clock early or late, fails within that sweep. Holding the enable high shows whether the forced top bit leaks into stored state, and whether the first enabled clock really lands on bit 7; an off-by-one here skips or repeats the MSB. Mid-conversion restarts, including one issued with the enable high, expose a start that loses priority. A chained pair converting codes across the 16-bit range catches a completion flag that reaches the lower stage one clock off, which would corrupt the low byte.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Code loaded on start: top bit is the first trial (0), all lower bits 1.
  function automatic logic [31:0] load_code(input int w);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < w - 1; i++) v[i] = 1'b1;
    return v;
  endfunction

  // One-hot marker for the most significant position.
  function automatic logic [31:0] top_marker(input int w);
    logic [31:0] v;
    v = '0;
    v[w-1] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/sar_trial_ring.sv
module sar_trial_ring #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] trial
);
  import sar_pkg::*;

  localparam logic [W-1:0] FIRST = W'(top_marker(W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     trial <= '0;
    else if (load)  trial <= FIRST;
    else if (step)  trial <= trial >> 1;
  end

  // R2: at most one bit is ever under trial
  a_r2_single_trial: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trial));

  // R7: a start always re-arms the top position
  a_r7_load_top: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> trial[W-1]);
endmodule

// File: rtl/sar_data_bits.sv
module sar_data_bits #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         ser_bit,
  input  logic [W-1:0] trial,
  output logic [W-1:0] bits
);
  import sar_pkg::*;

  localparam logic [W-1:0] INIT = W'(load_code(W));

  for (genvar i = 0; i < W; i++) begin : g_cell
    logic next_is_trial;
    if (i == W - 1) begin : g_top
      assign next_is_trial = 1'b0;
    end else begin : g_low
      assign next_is_trial = trial[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    bits[i] <= 1'b1;
      else if (load)                 bits[i] <= INIT[i];
      else if (step && trial[i])     bits[i] <= ser_bit;
      else if (step && next_is_trial) bits[i] <= 1'b0;
    end
  end

  // R6: a step at the top position captures the serial bit into the MSB
  a_r6_msb_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && trial[W-1]) |=> bits[W-1] == $past(ser_bit));
endmodule

// File: rtl/sar_register.sv
module sar_register #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_n,
  input  logic         enable_n,
  input  logic         ser_bit,
  output logic [W-1:0] q,
  output logic         q7_bar,
  output logic         done_n
);
  logic         load;
  logic         step;
  logic         waiting;
  logic [W-1:0] trial;
  logic [W-1:0] bits;

  assign load    = !start_n;
  assign step    = start_n && !enable_n;
  assign waiting = trial[W-1];

  sar_trial_ring #(.W(W)) u_ring (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .trial (trial)
  );

  sar_data_bits #(.W(W)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .ser_bit (ser_bit),
    .trial   (trial),
    .bits    (bits)
  );

  // Top bit is forced high only on the output while held idle.
  assign q      = {bits[W-1] | (enable_n & waiting), bits[W-2:0]};
  assign q7_bar = ~q[W-1];
  assign done_n = |trial;

  // R1: start leaves a busy stage with all lower bits high
  a_r1_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    !start_n |=> (done_n && (&q[W-2:0])));

  // R4: a finished stage holds its result until the next start
  a_r4_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && !done_n) |=> (!done_n && $stable(bits)));

  // R5: a waiting stage does not advance while disabled
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (start_n && enable_n && waiting) |=> (waiting && $stable(bits)));

  // R3: deciding the lowest bit completes the conversion
  a_r3_finish: assert property (@(posedge clk) disable iff (!rst_n)
    (step && trial[0]) |=> !done_n);
endmodule

// File: tb/test_sar_register.sv
module test_sar_register;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1;
  logic enable_n = 1'b1;
  logic ser_bit = 1'b0;
  logic [W-1:0] q;
  logic q7_bar, done_n;

  logic c_start_n = 1'b1;
  logic c_ser = 1'b0;
  logic c_en_hi = 1'b0;
  logic [W-1:0] qh, ql;
  logic qh_bar, ql_bar, dh_n, dl_n;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sar_register #(.W(W)) i_sar_register (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .enable_n(enable_n),
    .ser_bit(ser_bit), .q(q), .q7_bar(q7_bar), .done_n(done_n));

  sar_register #(.W(W)) u_hi (
    .clk(clk), .rst_n(rst_n), .start_n(c_start_n), .enable_n(c_en_hi),
    .ser_bit(c_ser), .q(qh), .q7_bar(qh_bar), .done_n(dh_n));

  sar_register #(.W(W)) u_lo (
    .clk(clk), .rst_n(rst_n), .start_n(c_start_n), .enable_n(dh_n),
    .ser_bit(c_ser), .q(ql), .q7_bar(ql_bar), .done_n(dl_n));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Expected code after k decided bits for a given target.
  function automatic logic [7:0] exp_step(input logic [7:0] t, input int k);
    logic [7:0] hi, lo;
    if (k >= W) return t;
    hi = ~((8'd1 << (W - k)) - 8'd1);
    lo = (8'd1 << (W - 1 - k)) - 8'd1;
    return (t & hi) | lo;
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    tick();
    // R10 reset state
    chk(q == 8'hFF, "R10 q", q, 8'hFF);
    chk(done_n == 1'b0, "R10 done_n", done_n, 0);
    rst_n = 1'b1;
    tick();

    // R1/R2/R3/R4/R8: full sweep with ideal comparator
    enable_n = 1'b0;
    for (int t = 0; t < 256; t++) begin
      start_n = 1'b0;
      tick();
      start_n = 1'b1;
      chk(q == 8'h7F, "R1 load", q, 8'h7F);
      chk(done_n == 1'b1, "R1 done_n", done_n, 1);
      for (int k = 1; k <= W; k++) begin
        ser_bit = (8'(t) > q);
        tick();
        chk(q == exp_step(8'(t), k), "R2 step", q, exp_step(8'(t), k));
        chk(q7_bar == ~q[7], "R8 q7_bar", q7_bar, ~q[7]);
        if (k < W) chk(done_n == 1'b1, "R3 busy", done_n, 1);
        else begin
          chk(done_n == 1'b0, "R3 done", done_n, 0);
          chk(q == 8'(t), "R3 result", q, t);
        end
      end
      for (int j = 0; j < 3; j++) begin
        ser_bit = j[0];
        tick();
        chk(q == 8'(t), "R4 hold", q, t);
        chk(done_n == 1'b0, "R4 done_n", done_n, 0);
      end
    end

    // R5/R6: wait with enable high, then capture MSB
    for (int v = 0; v < 2; v++) begin
      enable_n = 1'b1;
      start_n = 1'b0;
      tick();
      start_n = 1'b1;
      chk(q == 8'hFF, "R5 forced", q, 8'hFF);
      chk(q7_bar == 1'b0, "R8 forced bar", q7_bar, 0);
      for (int j = 0; j < 4; j++) begin
        ser_bit = j[0];
        tick();
        chk(q == 8'hFF, "R5 idle", q, 8'hFF);
        chk(done_n == 1'b1, "R5 done_n", done_n, 1);
      end
      enable_n = 1'b0;
      #1;
      chk(q == 8'h7F, "R5 release", q, 8'h7F);
      ser_bit = v[0];
      tick();
      chk(q == (v ? 8'hBF : 8'h3F), "R6 msb", q, v ? 8'hBF : 8'h3F);
    end

    // R7: restart mid-conversion with enable high
    start_n = 1'b0;
    tick();
    start_n = 1'b1;
    for (int j = 0; j < 3; j++) begin
      ser_bit = 1'b1;
      tick();
    end
    chk(q == 8'hEF, "R7 partial", q, 8'hEF);
    enable_n = 1'b1;
    start_n = 1'b0;
    tick();
    start_n = 1'b1;
    enable_n = 1'b0;
    #1;
    chk(q == 8'h7F, "R7 restart", q, 8'h7F);
    chk(done_n == 1'b1, "R7 done_n", done_n, 1);

    // R9: two chained stages
    for (int idx = 0; idx < 256; idx++) begin
      logic [15:0] tgt;
      tgt = 16'(idx * 40503 + 4660);
      if (idx == 0) tgt = 16'h0000;
      if (idx == 255) tgt = 16'hFFFF;
      c_start_n = 1'b0;
      tick();
      c_start_n = 1'b1;
      chk(ql == 8'hFF, "R5 chain idle", ql, 8'hFF);
      for (int k = 1; k <= 2 * W; k++) begin
        c_ser = (tgt > {qh, ql});
        tick();
        if (k < W) chk(ql == 8'hFF, "R5 chain wait", ql, 8'hFF);
        if (k == W) begin
          chk(qh == tgt[15:8], "R9 upper", qh, tgt[15:8]);
          chk(dh_n == 1'b0, "R9 upper done", dh_n, 0);
          chk(ql == 8'h7F, "R9 lower armed", ql, 8'h7F);
        end
        if (k < 2 * W) chk(dl_n == 1'b1, "R9 lower busy", dl_n, 1);
      end
      chk({qh, ql} == tgt, "R9 result", {qh, ql}, tgt);
      chk(dl_n == 1'b0, "R9 lower done", dl_n, 0);
    end

    finish_run();
  end
endmodule